// File: doc/BRIEF.md
# Flux interval timing encoder

This block measures the spacing between successive pulses on one asynchronous read-data line, such as the flux-transition output of a disk drive. It counts clock cycles from each rising edge to the next and turns every measured interval into a short run of bytes. Each byte carries a timing field in its lower seven bits and an externally supplied flag in its top bit. A byte is presented together with a one-cycle valid strobe, so the stream can be pushed directly into a FIFO.

An interval too long for seven bits is sent as a number of overflow tokens followed by one data byte. A token is worth 127 counts and has a timing field of zero. A data byte always carries a value from 1 to 127. Because zero never appears as data, a consumer can decode the stream by adding 127 per token and then adding the data value. This holds for every interval, including exact multiples of 128.

Timing is fully synchronous. The pulse line passes through a two-flop synchronizer, a rising-edge detector follows it, and an accumulator advances on every clock. The first edge after enable only starts the measurement.

Top module: `flux_interval_encoder`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it is released, out_valid is 0 and out_byte is 0x00.
- R2: The first rising edge of flux_in seen after acq_en goes high starts timing and produces no byte.
- R3: An interval of L clocks with 1 <= L <= 127 yields one byte with out_byte[6:0] = L. Its strobe rises after the third rising clock edge at which flux_in is sampled high.
- R4: An overflow token is a byte with out_byte[6:0] = 0. The k-th token of an interval appears 127*k cycles after the point at which a data byte for a pulse coinciding with the interval's start would have appeared.
- R5: An interval of L > 127 clocks yields floor((L-1)/127) tokens followed by a data byte equal to L - 127*tokens, which lies in 1..127. For example, 128 gives 0,1; 254 gives 0,127; 255 gives 0,0,1.
- R6: The edge that ends one interval also starts the next one, with no cycles lost between them.
- R7: out_byte[7] equals ext_flag as sampled at the clock edge that registers the byte.
- R8: Each byte is strobed for exactly one cycle, and out_byte is 0x00 in every cycle where out_valid is low.
- R9: While acq_en is low, no byte is produced and any open interval is dropped. After acq_en rises again, the first edge only re-arms timing, as in R2.
- R10: Only rising edges count. A pulse held high for many cycles ends one interval, and overflow tokens continue while it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one count per cycle |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition enable |
| ext_flag | input | 1 | Flag copied into bit 7 of each byte |
| flux_in | input | 1 | Asynchronous pulse input |
| out_valid | output | 1 | One-cycle strobe per emitted byte |
| out_byte | output | 8 | {flag, timing field} |

## Verification
If the accumulator holds a wrong value, the error shows up either as a wrong data byte on the next pulse or as a token one or more cycles away from its 127-cycle slot. The bench's per-cycle comparison therefore reports it on the first cycle where it becomes visible. An arming state that is out of step shows up as an extra data byte, or a missing one, three cycles after the first edge following enable. A fault in the synchronizer or in the output register shifts every strobe by whole cycles, which fails the next expected byte. The long-interval cases, both exact multiples of 128 and values on each side of them, expose any off-by-one in the wrap point within one interval.

// File: rtl/flux_enc_pkg.sv
package flux_enc_pkg;

    localparam int FE_TIME_W = 7;
    localparam int FE_SYNC_N = 2;

    typedef enum logic {
        ARM_IDLE,
        ARM_RUN
    } arm_state_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_TOKEN = 2'd1,
        EV_DATA  = 2'd2
    } emit_kind_e;

endpackage

// File: rtl/fe_edge_sync.sv
module fe_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[LAST-1:0], din};
        end
    end

    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    assign rise = sh[LAST-1] & ~sh[LAST];

endmodule

// File: rtl/fe_interval_acc.sv
module fe_interval_acc
    import flux_enc_pkg::*;
#(
    parameter int TIME_W = FE_TIME_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              edge_seen,
    output emit_kind_e        kind,
    output logic [TIME_W-1:0] field
);
    localparam logic [TIME_W-1:0] WRAP = '1;
    localparam logic [TIME_W-1:0] ONE  = TIME_W'(1);

    arm_state_e        state;
    logic [TIME_W-1:0] acc;

    always_comb begin
        kind  = EV_NONE;
        field = '0;
        if (en && state == ARM_RUN) begin
            if (edge_seen) begin
                kind  = EV_DATA;
                field = acc;
            end else if (acc == WRAP) begin
                kind = EV_TOKEN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= ARM_IDLE;
            acc   <= '0;
        end else if (state == ARM_IDLE) begin
            if (edge_seen) begin
                state <= ARM_RUN;
                acc   <= ONE;
            end
        end else if (edge_seen || acc == WRAP) begin
            acc <= ONE;
        end else begin
            acc <= acc + ONE;
        end
    end

endmodule

// File: rtl/fe_byte_out.sv
module fe_byte_out
    import flux_enc_pkg::*;
#(
    parameter int TIME_W = FE_TIME_W
) (
    input  logic              clk,
    input  logic              rst,
    input  emit_kind_e        kind,
    input  logic [TIME_W-1:0] field,
    input  logic              flag,
    output logic              valid,
    output logic [TIME_W:0]   data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            data  <= '0;
        end else begin
            valid <= (kind != EV_NONE);
            case (kind)
                EV_DATA:  data <= {flag, field};
                EV_TOKEN: data <= {flag, {TIME_W{1'b0}}};
                default:  data <= '0;
            endcase
        end
    end

endmodule

// File: rtl/flux_interval_encoder.sv
module flux_interval_encoder
    import flux_enc_pkg::*;
#(
    parameter int TIME_W = FE_TIME_W,
    parameter int SYNC_N = FE_SYNC_N
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acq_en,
    input  logic            ext_flag,
    input  logic            flux_in,
    output logic            out_valid,
    output logic [TIME_W:0] out_byte
);
    logic              rise;
    emit_kind_e        kind;
    logic [TIME_W-1:0] field;

    fe_edge_sync #(.STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (flux_in),
        .rise (rise)
    );

    fe_interval_acc #(.TIME_W(TIME_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .en        (acq_en),
        .edge_seen (rise),
        .kind      (kind),
        .field     (field)
    );

    fe_byte_out #(.TIME_W(TIME_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .field (field),
        .flag  (ext_flag),
        .valid (out_valid),
        .data  (out_byte)
    );

endmodule

// File: rtl/fe_checker.sv
module fe_checker #(
    parameter int TIME_W = 7
) (
    input logic            clk,
    input logic            rst,
    input logic            acq_en,
    input logic            ext_flag,
    input logic            out_valid,
    input logic [TIME_W:0] out_byte
);
    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> out_byte == '0);

    // R9
    disabled_silent_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!acq_en) |-> !out_valid);

    // R7
    flag_copy_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_byte[TIME_W] == $past(ext_flag));

    // R4
    token_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_byte[TIME_W-1:0] == '0) |=> !(out_valid && out_byte[TIME_W-1:0] == '0));

    // R3
    data_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_byte[TIME_W-1:0] != '0) |=> !out_valid);

endmodule

bind flux_interval_encoder fe_checker #(.TIME_W(TIME_W)) u_fe_chk (
    .clk       (clk),
    .rst       (rst),
    .acq_en    (acq_en),
    .ext_flag  (ext_flag),
    .out_valid (out_valid),
    .out_byte  (out_byte)
);

// File: tb/flux_interval_encoder_bench.sv
`timescale 1ns/1ps
module flux_interval_encoder_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acq_en = 1'b0;
    logic       ext_flag = 1'b0;
    logic       flux_in = 1'b0;
    logic       out_valid;
    logic [7:0] out_byte;

    always #2.5 clk = ~clk;

    flux_interval_encoder u_flux_interval_encoder (
        .clk       (clk),
        .rst       (rst),
        .acq_en    (acq_en),
        .ext_flag  (ext_flag),
        .flux_in   (flux_in),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

    typedef struct {
        int t;
        bit dis;
    } ev_t;

    int     cyc = 0;
    int     checks = 0;
    int     fails = 0;
    bit     chk_on = 0;
    bit     flag_mode = 0;
    bit     en_model = 0;
    bit     armed_model = 0;
    int     prev_pulse = 0;
    int     last_fire = 0;
    string  cur_req = "R3";
    bit     done = 0;
    int     exp_map[int];
    bit     flag_at[int];
    ev_t    evq[$];

    always @(posedge clk) begin
        cyc = cyc + 1;
        flag_at[cyc] = ext_flag;
    end

    always @(negedge clk) begin
        if (flag_mode) ext_flag <= cyc[0] ^ cyc[2] ^ cyc[5];
    end

    // reference model compared every cycle
    always @(negedge clk) begin
        if (chk_on && !done) begin
            automatic int       v = cyc;
            automatic bit       ev = 0;
            automatic int       fld = 0;
            automatic logic [7:0] eb;
            automatic string    tag = "R8";
            if (exp_map.exists(v)) begin
                ev  = 1;
                fld = exp_map[v];
                tag = cur_req;
            end
            for (int i = evq.size() - 1; i >= 0; i--) begin
                if (evq[i].dis ? (evq[i].t <= v - 1) : (evq[i].t <= v - 3)) begin
                    if (!evq[i].dis && (v - 3 - evq[i].t) > 0 && ((v - 3 - evq[i].t) % 127) == 0) begin
                        ev  = 1;
                        fld = 0;
                        tag = "R4";
                    end
                    break;
                end
            end
            eb = ev ? {flag_at[v], 7'(fld)} : 8'h00;
            checks++;
            if (out_valid !== ev || out_byte !== eb) begin
                fails++;
                $display("FAIL %s cycle %0d: valid=%0b byte=%02h expected valid=%0b byte=%02h",
                         tag, v, out_valid, out_byte, ev, eb);
            end
        end
    end

    task automatic fire_pulse(input int hold);
        int n = cyc;
        if (en_model) begin
            if (armed_model) begin
                int len  = n - prev_pulse;
                int ntok = (len - 1) / 127;
                exp_map[n + 3] = len - 127 * ntok;
            end
            evq.push_back('{t: n, dis: 1'b0});
            armed_model = 1;
            prev_pulse  = n;
        end
        last_fire = n;
        flux_in = 1'b1;
        repeat (hold) @(negedge clk);
        flux_in = 1'b0;
    endtask

    task automatic pulse_after(input int len, input int hold);
        while (cyc < last_fire + len) @(negedge clk);
        fire_pulse(hold);
    endtask

    task automatic disable_acq();
        int d = cyc;
        int kill[$];
        acq_en = 1'b0;
        en_model = 0;
        armed_model = 0;
        evq.push_back('{t: d, dis: 1'b1});
        foreach (exp_map[k]) if (k > d) kill.push_back(k);
        foreach (kill[j]) exp_map.delete(kill[j]);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_byte !== 8'h00) begin
            fails++;
            $display("FAIL R1: valid=%0b byte=%02h expected valid=0 byte=00", out_valid, out_byte);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_byte !== 8'h00) begin
            fails++;
            $display("FAIL R1: after release valid=%0b byte=%02h expected valid=0 byte=00", out_valid, out_byte);
        end
        chk_on = 1;
        acq_en = 1'b1;
        en_model = 1;
        repeat (4) @(negedge clk);

        // R2: arming edge, then R3 short intervals
        cur_req = "R2";
        fire_pulse(2);
        cur_req = "R3";
        pulse_after(5, 2);
        pulse_after(4, 2);
        pulse_after(37, 2);
        pulse_after(126, 2);
        pulse_after(127, 2);

        // R5: long intervals, multiples of 128 and neighbours
        cur_req = "R5";
        pulse_after(128, 2);
        pulse_after(129, 2);
        pulse_after(254, 2);
        pulse_after(255, 2);
        pulse_after(256, 2);
        pulse_after(381, 2);
        pulse_after(382, 2);
        pulse_after(384, 2);
        pulse_after(640, 2);

        // R6: back-to-back short intervals
        cur_req = "R6";
        for (int i = 0; i < 8; i++) pulse_after(4 + i, 2);

        // R7: flag changes every few cycles
        cur_req = "R7";
        flag_mode = 1;
        for (int i = 0; i < 10; i++) pulse_after(6 + 31 * i, 2);
        flag_mode = 0;
        @(negedge clk);
        ext_flag = 1'b1;

        // R10: pulse held high through overflow
        cur_req = "R10";
        pulse_after(20, 300);
        pulse_after(400, 2);

        // R9: disable with an open interval, pulses while disabled, re-arm
        cur_req = "R9";
        pulse_after(50, 2);
        repeat (200) @(negedge clk);
        disable_acq();
        repeat (10) @(negedge clk);
        fire_pulse(2);
        pulse_after(30, 2);
        repeat (300) @(negedge clk);
        acq_en = 1'b1;
        en_model = 1;
        repeat (5) @(negedge clk);
        fire_pulse(2);
        pulse_after(50, 2);
        pulse_after(128, 2);

        repeat (20) @(negedge clk);
        done = 1;
        summary();
        $finish;
    end

endmodule